// File: doc/BRIEF.md
# Power-Off Notice Controller

This block is the device-side keeper of a one-byte power-down notice setting held in the extended configuration space. A host uses a configuration write to tell the device it is running normally, that power will soon be removed (quickly or with more time), or that the core supply will be cut once the device is asleep. For the three warning settings, the block raises busy on the DAT0 line while the device gets ready. Busy ends when the preparation logic reports completion, when the timeout for that setting runs out, or when a high-priority interrupt arrives.

The block also follows the device's transfer, standby and sleep states. Select and deselect commands move it between transfer and standby. The sleep/awake command moves it between standby and sleep, and only when the notice setting allows it. Any ordinary command that follows a warning setting returns the byte to "powered on". An attempt to write the byte back to zero, or to write it with an undefined value, is refused with a one-cycle switch-error pulse.

Top module: `pwrdn_notice_ctrl`

## Requirements
- R1: After reset the notice byte is 0x00 (not notified), busy is low, switch_err is low and dev_state is 0 (transfer; standby is 1 and sleep is 2).
- R2: In transfer state with busy low, a write of 0x01 (powered on), 0x02 (short power-off), 0x03 (long power-off) or 0x04 (sleep notice) appears on notice_val one cycle after the write strobe, with no switch error.
- R3: A write of 0x00 while the byte is non-zero gives a switch_err pulse in the next cycle and leaves the byte unchanged. A write of 0x00 while the byte is still 0x00 gives no error.
- R4: A write of 0x05 to 0xFF, or any write outside transfer state, gives a switch_err pulse and leaves the byte unchanged. The byte never holds a value above 0x04.
- R5: Writing 0x02, 0x03 or 0x04 raises busy in the next cycle. If prep_done is high in a cycle while busy is high, busy falls in the following cycle and the byte keeps its value.
- R6: If prep_done never arrives, busy stays high for exactly SHORT_TMO cycles after 0x02 and LONG_TMO cycles after 0x03. After 0x04 it stays high for slp_tmo_code×SLP_UNIT cycles, where a code of 0 counts as 1.
- R7: While the byte holds 0x02, 0x03 or 0x04, any further command returns it to 0x01 and ends busy. This covers an ordinary command, a write made during busy, a select or deselect, an awake issued outside sleep, and a rejected sleep request. There is one exception: a deselect or a sleep request made while the byte is 0x04 with busy low keeps 0x04.
- R8: A high-priority interrupt during busy drops busy in the next cycle and sets the byte to 0x01. When busy is low, an interrupt has no effect.
- R9: A sleep request is accepted only in standby, and only when the byte is 0x01 or is 0x04 with busy low. An accepted request moves dev_state to 2 and keeps the byte. Otherwise the request leaves dev_state unchanged.
- R10: An awake command in sleep moves dev_state to standby and sets the byte to 0x01. While asleep, ordinary commands and select/deselect are ignored, and writes give a switch error.
- R11: Outside sleep, a select with sel_hit=1 moves dev_state to transfer and a select with sel_hit=0 moves it to standby.
- R12: When several strobes are high in the same cycle, only the first one in this order is acted on: interrupt, write, select, sleep/awake, ordinary command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe for the notice byte |
| wr_data | input | 8 | Value written |
| cmd_stb | input | 1 | Any other command received |
| hpi_stb | input | 1 | High-priority interrupt received |
| slp_stb | input | 1 | Sleep/awake command received |
| slp_enter | input | 1 | 1 = sleep request, 0 = awake |
| sel_stb | input | 1 | Select/deselect command received |
| sel_hit | input | 1 | 1 = this device selected, 0 = deselected |
| prep_done | input | 1 | Power-down preparation finished |
| slp_tmo_code | input | 8 | Sleep-notice timeout code from the configuration space |
| notice_val | output | 8 | Current notice byte |
| busy | output | 1 | Busy indication for DAT0 |
| dev_state | output | 2 | 0 transfer, 1 standby, 2 sleep |
| switch_err | output | 1 | One-cycle switch-error pulse |

## Verification
The bench builds the block with SHORT_TMO=20, LONG_TMO=60 and SLP_UNIT=4, and drives slp_tmo_code=7 so the sleep-notice window is 28 cycles. These small values let the bench measure each timeout window cycle by cycle, alongside early release through prep_done and interrupt. With the windows that short, the bench can also run the full sequence in one short run: notice, deselect, sleep, ignored traffic, awake, reselect.

// File: rtl/pwrdn_notice_pkg.sv
package pwrdn_notice_pkg;

  localparam logic [7:0] PN_NONE  = 8'h00;
  localparam logic [7:0] PN_ON    = 8'h01;
  localparam logic [7:0] PN_SHORT = 8'h02;
  localparam logic [7:0] PN_LONG  = 8'h03;
  localparam logic [7:0] PN_SLEEP = 8'h04;

  typedef enum logic [1:0] {
    ST_XFER  = 2'd0,
    ST_STBY  = 2'd1,
    ST_SLEEP = 2'd2
  } dev_state_e;

  typedef struct packed {
    logic apply;
    logic err;
    logic restore;
    logic abort;
    logic go_xfer;
    logic go_stby;
    logic go_sleep;
    logic wake;
  } pn_evt_t;

endpackage

// File: rtl/pwrdn_cmd_decode.sv
module pwrdn_cmd_decode
  import pwrdn_notice_pkg::*;
(
  input  logic       hpi_i,
  input  logic       wr_i,
  input  logic [7:0] wr_data_i,
  input  logic       sel_i,
  input  logic       sel_hit_i,
  input  logic       slp_i,
  input  logic       slp_enter_i,
  input  logic       cmd_i,
  input  logic [7:0] value_i,
  input  logic       busy_i,
  input  dev_state_e state_i,
  output pn_evt_t    evt_o
);

  logic notified;
  logic idle_slp;
  logic asleep;

  always_comb begin
    notified = (value_i == PN_SHORT) || (value_i == PN_LONG) || (value_i == PN_SLEEP);
    idle_slp = (value_i == PN_SLEEP) && !busy_i;
    asleep   = (state_i == ST_SLEEP);
    evt_o    = '0;
    if (hpi_i) begin
      if (busy_i) begin
        evt_o.restore = 1'b1;
        evt_o.abort   = 1'b1;
      end
    end else if (wr_i) begin
      if (state_i != ST_XFER) begin
        evt_o.err = 1'b1;
      end else if (busy_i) begin
        evt_o.restore = 1'b1;
        evt_o.abort   = 1'b1;
      end else if (wr_data_i == PN_NONE) begin
        evt_o.err = (value_i != PN_NONE);
      end else if (wr_data_i > PN_SLEEP) begin
        evt_o.err = 1'b1;
      end else begin
        evt_o.apply = 1'b1;
      end
    end else if (sel_i) begin
      if (!asleep) begin
        evt_o.go_xfer = sel_hit_i;
        evt_o.go_stby = !sel_hit_i;
        evt_o.restore = notified && !(!sel_hit_i && idle_slp);
        evt_o.abort   = busy_i;
      end
    end else if (slp_i) begin
      if (slp_enter_i) begin
        if ((state_i == ST_STBY) && ((value_i == PN_ON) || idle_slp)) begin
          evt_o.go_sleep = 1'b1;
        end else if (!asleep) begin
          evt_o.restore = notified;
          evt_o.abort   = busy_i;
        end
      end else if (asleep) begin
        evt_o.wake    = 1'b1;
        evt_o.restore = 1'b1;
      end else begin
        evt_o.restore = notified;
        evt_o.abort   = busy_i;
      end
    end else if (cmd_i && !asleep) begin
      evt_o.restore = notified;
      evt_o.abort   = busy_i;
    end
  end

endmodule

// File: rtl/pwrdn_field_reg.sv
module pwrdn_field_reg
  import pwrdn_notice_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pn_evt_t    evt_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] value_o,
  output logic       err_o,
  output logic       start_o
);

  logic [7:0] value_q, value_d;
  logic       err_q, err_d;
  logic       value_en;

  always_comb begin
    value_en = evt_i.restore || evt_i.apply;
    value_d  = evt_i.restore ? PN_ON : wr_data_i;
    err_d    = evt_i.err;
    start_o  = evt_i.apply && (wr_data_i >= PN_SHORT) && (wr_data_i <= PN_SLEEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= PN_NONE;
    end else if (value_en) begin
      value_q <= value_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign value_o = value_q;
  assign err_o   = err_q;

  AST_VALUE_DEFINED: assert property (@(posedge clk) disable iff (!rst_n)
    value_q <= PN_SLEEP); // R4

endmodule

// File: rtl/pwrdn_busy_timer.sv
module pwrdn_busy_timer #(
  parameter int SHORT_TMO = 2000,
  parameter int LONG_TMO  = 200000,
  parameter int SLP_UNIT  = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] code_i,
  input  logic [7:0] slp_tmo_i,
  input  logic       abort_i,
  input  logic       done_i,
  output logic       busy_o
);

  localparam int SLP_MAX = 255 * SLP_UNIT;
  localparam int MAX_A   = (SHORT_TMO > LONG_TMO) ? SHORT_TMO : LONG_TMO;
  localparam int MAXL    = (MAX_A > SLP_MAX) ? MAX_A : SLP_MAX;
  localparam int CW      = $clog2(MAXL + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim_q, lim_d;
  logic [CW-1:0] slp_eff, slp_lim, new_lim;
  logic          busy_q, busy_d;
  logic          tmr_en;

  always_comb begin
    slp_eff = (slp_tmo_i == 8'd0) ? CW'(1) : CW'(slp_tmo_i);
    slp_lim = slp_eff * CW'(SLP_UNIT);
    case (code_i)
      8'h02:   new_lim = CW'(SHORT_TMO);
      8'h03:   new_lim = CW'(LONG_TMO);
      default: new_lim = slp_lim;
    endcase
  end

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    lim_d  = lim_q;
    tmr_en = start_i || busy_q;
    if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      lim_d  = new_lim;
    end else if (busy_q) begin
      if (abort_i || done_i || (cnt_q == lim_q - CW'(1))) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      lim_q  <= '0;
    end else if (tmr_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      lim_q  <= lim_d;
    end
  end

  assign busy_o = busy_q;

  AST_BUSY_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < lim_q)); // R6

  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && done_i && !start_i) |=> !busy_q); // R5

endmodule

// File: rtl/pwrdn_sleep_fsm.sv
module pwrdn_sleep_fsm
  import pwrdn_notice_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pn_evt_t    evt_i,
  output dev_state_e state_o
);

  dev_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_XFER:  if (evt_i.go_stby) state_d = ST_STBY;
      ST_STBY:  if (evt_i.go_sleep) state_d = ST_SLEEP;
                else if (evt_i.go_xfer) state_d = ST_XFER;
      ST_SLEEP: if (evt_i.wake) state_d = ST_STBY;
      default:  state_d = ST_XFER;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_XFER;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

  AST_WAKE_VIA_STBY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP) |=> (state_q != ST_XFER)); // R10

endmodule

// File: rtl/pwrdn_notice_ctrl.sv
module pwrdn_notice_ctrl
  import pwrdn_notice_pkg::*;
#(
  parameter int SHORT_TMO = 2000,
  parameter int LONG_TMO  = 200000,
  parameter int SLP_UNIT  = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       cmd_stb,
  input  logic       hpi_stb,
  input  logic       slp_stb,
  input  logic       slp_enter,
  input  logic       sel_stb,
  input  logic       sel_hit,
  input  logic       prep_done,
  input  logic [7:0] slp_tmo_code,
  output logic [7:0] notice_val,
  output logic       busy,
  output logic [1:0] dev_state,
  output logic       switch_err
);

  pn_evt_t    evt;
  dev_state_e state;
  logic [7:0] value;
  logic       busy_int;
  logic       start;
  logic       in_sleep;

  pwrdn_cmd_decode i_decode (
    .hpi_i       (hpi_stb),
    .wr_i        (wr_en),
    .wr_data_i   (wr_data),
    .sel_i       (sel_stb),
    .sel_hit_i   (sel_hit),
    .slp_i       (slp_stb),
    .slp_enter_i (slp_enter),
    .cmd_i       (cmd_stb),
    .value_i     (value),
    .busy_i      (busy_int),
    .state_i     (state),
    .evt_o       (evt)
  );

  pwrdn_field_reg i_field (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt),
    .wr_data_i (wr_data),
    .value_o   (value),
    .err_o     (switch_err),
    .start_o   (start)
  );

  pwrdn_busy_timer #(
    .SHORT_TMO (SHORT_TMO),
    .LONG_TMO  (LONG_TMO),
    .SLP_UNIT  (SLP_UNIT)
  ) i_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .code_i    (wr_data),
    .slp_tmo_i (slp_tmo_code),
    .abort_i   (evt.abort),
    .done_i    (prep_done),
    .busy_o    (busy_int)
  );

  pwrdn_sleep_fsm i_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt),
    .state_o (state)
  );

  assign notice_val = value;
  assign busy       = busy_int;
  assign dev_state  = state;
  assign in_sleep   = (state == ST_SLEEP);

  AST_BUSY_NEEDS_NOTICE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_int |-> ((value == PN_SHORT) || (value == PN_LONG) || (value == PN_SLEEP))); // R5

  AST_ZERO_WRITE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hpi_stb && !busy_int && (wr_data == PN_NONE) && (value != PN_NONE))
    |=> (switch_err && (value == $past(value)))); // R3

  AST_HPI_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_int && hpi_stb) |=> (!busy_int && (value == PN_ON))); // R8

  AST_SLEEP_ENTRY_OK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sleep) |-> (($past(value) == PN_ON) ||
                         (($past(value) == PN_SLEEP) && !$past(busy_int)))); // R9

  AST_WAKE_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_sleep) |-> (value == PN_ON)); // R10

endmodule

// File: tb/test_pwrdn_notice_ctrl.sv
module test_pwrdn_notice_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       cmd_stb = 1'b0;
  logic       hpi_stb = 1'b0;
  logic       slp_stb = 1'b0;
  logic       slp_enter = 1'b0;
  logic       sel_stb = 1'b0;
  logic       sel_hit = 1'b0;
  logic       prep_done = 1'b0;
  logic [7:0] slp_tmo_code = 8'd7;
  logic [7:0] notice_val;
  logic       busy;
  logic [1:0] dev_state;
  logic       switch_err;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pwrdn_notice_ctrl #(.SHORT_TMO(20), .LONG_TMO(60), .SLP_UNIT(4)) i_pwrdn_notice_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .cmd_stb(cmd_stb),
    .hpi_stb(hpi_stb), .slp_stb(slp_stb), .slp_enter(slp_enter), .sel_stb(sel_stb),
    .sel_hit(sel_hit), .prep_done(prep_done), .slp_tmo_code(slp_tmo_code),
    .notice_val(notice_val), .busy(busy), .dev_state(dev_state), .switch_err(switch_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d; tick(); wr_en = 1'b0;
  endtask

  task automatic do_cmd();
    cmd_stb = 1'b1; tick(); cmd_stb = 1'b0;
  endtask

  task automatic do_hpi();
    hpi_stb = 1'b1; tick(); hpi_stb = 1'b0;
  endtask

  task automatic do_sel(input logic hit);
    sel_stb = 1'b1; sel_hit = hit; tick(); sel_stb = 1'b0;
  endtask

  task automatic do_slp(input logic enter);
    slp_stb = 1'b1; slp_enter = enter; tick(); slp_stb = 1'b0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; tick(); end
  endtask

  task automatic t_reset();
    chk("R1 value", notice_val, 0);
    chk("R1 busy", busy, 0);
    chk("R1 state", dev_state, 0);
    chk("R1 err", switch_err, 0);
  endtask

  task automatic t_writes();
    do_write(8'h00);
    chk("R3 zero at start no err", switch_err, 0);
    chk("R3 zero at start value", notice_val, 0);
    do_write(8'h01);
    chk("R2 write 01", notice_val, 1);
    chk("R2 no err", switch_err, 0);
    do_write(8'h00);
    chk("R3 zero err", switch_err, 1);
    chk("R3 zero kept", notice_val, 1);
    do_write(8'h05);
    chk("R4 05 err", switch_err, 1);
    chk("R4 05 kept", notice_val, 1);
    do_write(8'hFF);
    chk("R4 FF err", switch_err, 1);
    chk("R4 FF kept", notice_val, 1);
  endtask

  task automatic t_timeouts();
    int n;
    do_write(8'h02);
    chk("R2 write 02", notice_val, 2);
    chk("R5 busy rises", busy, 1);
    busy_len(n);
    chk("R6 short window", n, 20);
    chk("R6 value after short", notice_val, 2);
    do_cmd();
    chk("R7 cmd restores", notice_val, 1);
    do_write(8'h03);
    chk("R2 write 03", notice_val, 3);
    busy_len(n);
    chk("R6 long window", n, 60);
    do_sel(1'b1);
    chk("R7 select restores", notice_val, 1);
    chk("R11 select xfer", dev_state, 0);
  endtask

  task automatic t_prep_done();
    do_write(8'h02);
    tick(); tick();
    prep_done = 1'b1; tick(); prep_done = 1'b0;
    chk("R5 prep_done ends busy", busy, 0);
    chk("R5 value kept", notice_val, 2);
    do_cmd();
    chk("R7 restore after prep", notice_val, 1);
  endtask

  task automatic t_hpi();
    int n;
    do_write(8'h03);
    tick(); tick();
    do_hpi();
    chk("R8 hpi busy", busy, 0);
    chk("R8 hpi value", notice_val, 1);
    do_write(8'h02);
    busy_len(n);
    do_hpi();
    chk("R8 idle hpi no effect", notice_val, 2);
    do_cmd();
    chk("R7 cmd after idle hpi", notice_val, 1);
  endtask

  task automatic t_write_busy();
    do_write(8'h02);
    do_write(8'h04);
    chk("R7 write in busy value", notice_val, 1);
    chk("R7 write in busy busy", busy, 0);
    chk("R7 write in busy no err", switch_err, 0);
  endtask

  task automatic t_sleep_path();
    int n;
    do_slp(1'b1);
    chk("R9 sleep from xfer rejected", dev_state, 0);
    do_write(8'h04);
    chk("R2 write 04", notice_val, 4);
    busy_len(n);
    chk("R6 sleep window", n, 28);
    do_sel(1'b0);
    chk("R11 deselect stby", dev_state, 1);
    chk("R7 deselect keeps 04", notice_val, 4);
    do_slp(1'b1);
    chk("R9 sleep accepted", dev_state, 2);
    chk("R9 sleep keeps 04", notice_val, 4);
    do_cmd();
    chk("R10 cmd ignored value", notice_val, 4);
    chk("R10 cmd ignored state", dev_state, 2);
    do_write(8'h02);
    chk("R10 write err asleep", switch_err, 1);
    chk("R10 write kept asleep", notice_val, 4);
    do_sel(1'b1);
    chk("R10 select ignored", dev_state, 2);
    do_slp(1'b0);
    chk("R10 awake state", dev_state, 1);
    chk("R10 awake value", notice_val, 1);
    do_slp(1'b1);
    chk("R9 sleep with 01", dev_state, 2);
    do_slp(1'b0);
    do_sel(1'b1);
    chk("R11 reselect xfer", dev_state, 0);
    do_write(8'h02);
    busy_len(n);
    do_sel(1'b0);
    chk("R7 deselect restores 02", notice_val, 1);
    do_sel(1'b1);
  endtask

  task automatic t_priority();
    wr_en = 1'b1; wr_data = 8'h02; cmd_stb = 1'b1; tick();
    wr_en = 1'b0; cmd_stb = 1'b0;
    chk("R12 write over cmd value", notice_val, 2);
    chk("R12 write over cmd busy", busy, 1);
    wr_en = 1'b1; wr_data = 8'h03; hpi_stb = 1'b1; tick();
    wr_en = 1'b0; hpi_stb = 1'b0;
    chk("R12 hpi over write value", notice_val, 1);
    chk("R12 hpi over write busy", busy, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_writes();
    t_timeouts();
    t_prep_done();
    t_hpi();
    t_write_busy();
    t_sleep_path();
    t_priority();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule